// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a serial slave that gives a master read and write access to a bank of 32 eight-bit registers. It uses one serial clock and one data line. The bidirectional pad sits outside the block. The block takes the received line value as an input and returns an output value together with an output enable. All sequencing happens on the falling edge of the serial clock, and the line value is sampled on that same edge.

While idle, the master holds the line low. A frame starts with a start bit (a 1), followed by two operation bits, five address bits sent most significant first, and eight data bits sent most significant first. The operation bits 0 then 0 select a write, and 1 then 0 select a read.

- On a write, the master drives every bit. The addressed register changes only when the last data bit arrives.
- On a read, one idle clock follows the last address bit. The slave then drives the eight data bits and releases the line.
- After every access, one further clock must pass before a new start bit can be recognised.

Top module: `tw_regbank_slave`

## Requirements
- R1: While reset is high on a falling clock edge, all 32 registers return to 0x00, the output enable goes low and the sequencer returns to idle.
- R2: In idle, a 0 sampled on a falling edge is ignored, and a 1 is taken as a start bit.
- R3: After a start bit, the operation bits 0 then 0 select a write. The next five samples form the address (bit 4 first) and the next eight form the data (bit 7 first). The register at that address takes the data on the edge that samples the eighth data bit.
- R4: After a start bit, the operation bits 1 then 0 select a read. The slave returns the content of the addressed register, bit 7 first, one bit per clock.
- R5: On a read, the output enable stays low during the clock that follows the last address bit. It is high for exactly the eight data clocks and low again in the clock after bit 0.
- R6: The operation bit pairs 0 then 1, and 1 then 1, abandon the frame. No register changes, the line is never driven, and a new start bit is accepted after one gap edge.
- R7: After any access, the first falling edge is a gap edge and its sample is ignored, even a 1. The edge after it is an idle edge again.
- R8: Registers hold independent values. A write to one address leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| sdat_in | input | 1 | Value received from the data line |
| sdat_out | output | 1 | Value the slave drives onto the data line |
| sdat_oe | output | 1 | High while the slave drives the data line |

## Verification
Most internal faults surface on the next read. A bit counter that is off by one shows within one frame: the output enable rises one clock early or late, or the returned byte is shifted by one bit position. A wrong address capture, or a write committed too early or not at all, shows as a wrong byte on a later read of that address or of a neighbouring one. A gap edge that is not ignored misaligns the following frame, so that frame's output-enable window and returned data are both wrong.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int TW_ADDR_W = 5;
    localparam int TW_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OP    = 3'd1,
        ST_ADDR  = 3'd2,
        ST_TURN  = 3'd3,
        ST_WDATA = 3'd4,
        ST_RDATA = 3'd5,
        ST_GAP   = 3'd6
    } seq_state_e;

    // operation code, first received bit in the upper position
    typedef enum logic [1:0] {
        OPC_WRITE = 2'b00,
        OPC_BAD0  = 2'b01,
        OPC_READ  = 2'b10,
        OPC_BAD1  = 2'b11
    } opcode_e;

    typedef struct packed {
        logic addr_shift;
        logic wdat_shift;
        logic wr_commit;
        logic rd_load;
        logic rd_shift;
    } seq_ctrl_t;

    function automatic logic op_is_valid(input logic [1:0] op);
        return (op == OPC_WRITE) || (op == OPC_READ);
    endfunction

    function automatic logic op_is_read(input logic [1:0] op);
        return op == OPC_READ;
    endfunction

endpackage

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
#(
    parameter int ADDR_W = TW_ADDR_W,
    parameter int DATA_W = TW_DATA_W
) (
    input  logic       sclk,
    input  logic       rst,
    input  logic       din,
    output seq_state_e state,
    output seq_ctrl_t  ctrl,
    output logic       drive
);
    localparam int MAXLEN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W  = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;
    logic             op_first;
    logic             rd_op;

    always_comb begin
        ctrl            = '0;
        ctrl.addr_shift = (state == ST_ADDR);
        ctrl.wdat_shift = (state == ST_WDATA);
        ctrl.wr_commit  = (state == ST_WDATA) && (cnt == DATA_LAST);
        ctrl.rd_load    = (state == ST_TURN);
        ctrl.rd_shift   = (state == ST_RDATA);
    end

    always_ff @(negedge sclk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            op_first <= 1'b0;
            rd_op    <= 1'b0;
            drive    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (din) state <= ST_OP;
                end
                ST_OP: begin
                    if (cnt == '0) begin
                        op_first <= din;
                        cnt      <= cnt + 1'b1;
                    end else begin
                        cnt   <= '0;
                        rd_op <= op_is_read({op_first, din});
                        state <= op_is_valid({op_first, din}) ? ST_ADDR : ST_GAP;
                    end
                end
                ST_ADDR: begin
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        state <= rd_op ? ST_TURN : ST_WDATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    drive <= 1'b1;
                    cnt   <= '0;
                    state <= ST_RDATA;
                end
                ST_WDATA: begin
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        state <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        drive <= 1'b0;
                        state <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
#(
    parameter int ADDR_W = TW_ADDR_W,
    parameter int DATA_W = TW_DATA_W
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              din,
    input  seq_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wr_val,
    output logic              msb
);
    logic [DATA_W-1:0] data_q;

    always_ff @(negedge sclk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (ctrl.addr_shift) addr_q <= {addr_q[ADDR_W-2:0], din};
            if (ctrl.rd_load)
                data_q <= load_val;
            else if (ctrl.wdat_shift)
                data_q <= {data_q[DATA_W-2:0], din};
            else if (ctrl.rd_shift)
                data_q <= {data_q[DATA_W-2:0], 1'b0};
        end
    end

    // final write bit arrives on the commit edge itself
    assign wr_val = {data_q[DATA_W-2:0], din};
    assign msb    = data_q[DATA_W-1];

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_pkg::*;
#(
    parameter int ADDR_W = TW_ADDR_W,
    parameter int DATA_W = TW_DATA_W
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] rd_val
);
    localparam int NREGS = 1 << ADDR_W;

    logic [DATA_W-1:0] bank [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        logic [DATA_W-1:0] q;
        always_ff @(negedge sclk) begin
            if (rst)
                q <= '0;
            else if (wr_en && (addr == ADDR_W'(g)))
                q <= wr_val;
        end
        assign bank[g] = q;
    end

    assign rd_val = bank[addr];

endmodule

// File: rtl/tw_regbank_slave.sv
module tw_regbank_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W = TW_ADDR_W,
    parameter int DATA_W = TW_DATA_W
) (
    input  logic sclk,
    input  logic rst,
    input  logic sdat_in,
    output logic sdat_out,
    output logic sdat_oe
);
    seq_state_e        state;
    seq_ctrl_t         ctrl;
    logic              drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] rd_val;
    logic              msb;
    logic              wr_en;

    tw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .sclk  (sclk),
        .rst   (rst),
        .din   (sdat_in),
        .state (state),
        .ctrl  (ctrl),
        .drive (drive)
    );

    tw_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .sclk     (sclk),
        .rst      (rst),
        .din      (sdat_in),
        .ctrl     (ctrl),
        .load_val (rd_val),
        .addr_q   (addr_q),
        .wr_val   (wr_val),
        .msb      (msb)
    );

    assign wr_en = ctrl.wr_commit;

    tw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .sclk   (sclk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr_q),
        .wr_val (wr_val),
        .rd_val (rd_val)
    );

    assign sdat_oe  = drive;
    assign sdat_out = drive & msb;

endmodule

// File: rtl/tw_regbank_slave_chk.sv
module tw_regbank_slave_chk
    import tw_pkg::*;
(
    input logic       sclk,
    input logic       rst,
    input logic       sdat_oe,
    input logic       sdat_out,
    input logic       wr_en,
    input seq_state_e state
);
    logic [3:0] oe_run;

    always_ff @(negedge sclk) begin
        if (rst)
            oe_run <= '0;
        else if (sdat_oe)
            oe_run <= (oe_run == 4'hF) ? oe_run : oe_run + 1'b1;
        else
            oe_run <= '0;
    end

    assert_reset_idle_R1: assert property (@(negedge sclk)
        rst |=> (!sdat_oe && state == ST_IDLE));

    assert_oe_after_turn_R5: assert property (@(negedge sclk) disable iff (rst)
        $rose(sdat_oe) |-> $past(state) == ST_TURN);

    assert_oe_run_len_R5: assert property (@(negedge sclk) disable iff (rst)
        $fell(sdat_oe) |-> oe_run == 4'd8);

    assert_oe_run_max_R4: assert property (@(negedge sclk) disable iff (rst)
        oe_run <= 4'd8);

    assert_no_write_while_driving_R3: assert property (@(negedge sclk) disable iff (rst)
        wr_en |-> !sdat_oe);

    assert_quiet_output_R6: assert property (@(negedge sclk) disable iff (rst)
        !sdat_oe |-> !sdat_out);

endmodule

bind tw_regbank_slave tw_regbank_slave_chk u_chk (
    .sclk     (sclk),
    .rst      (rst),
    .sdat_oe  (sdat_oe),
    .sdat_out (sdat_out),
    .wr_en    (wr_en),
    .state    (state)
);

// File: tb/tw_regbank_slave_tb.sv
module tw_regbank_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {address, data}
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd0,  8'hA5}, {5'd31, 8'h3C}, {5'd5,  8'hFF},
        {5'd6,  8'h01}, {5'd16, 8'h80}, {5'd4,  8'h5A}
    };

    logic sclk = 1'b0;
    logic rst  = 1'b1;
    logic sdat_in = 1'b0;
    logic sdat_out;
    logic sdat_oe;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    tw_regbank_slave u_dut (
        .sclk     (sclk),
        .rst      (rst),
        .sdat_in  (sdat_in),
        .sdat_out (sdat_out),
        .sdat_oe  (sdat_oe)
    );

    always #(CLK_PERIOD/2) sclk = ~sclk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(posedge sclk);
        sdat_in = b;
    endtask

    task automatic send_head(input logic o1, input logic o0, input logic [4:0] a);
        send_bit(1'b1);
        send_bit(o1);
        send_bit(o0);
        for (int i = 4; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic gap);
        send_head(1'b0, 1'b0, a);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(gap);
    endtask

    // returns byte; checks the enable window
    task automatic rd(input logic [4:0] a, input string req, output logic [7:0] got);
        logic win_ok;
        send_head(1'b1, 1'b0, a);
        @(posedge sclk);
        sdat_in = 1'b0;
        win_ok = !sdat_oe;
        for (int i = 7; i >= 0; i--) begin
            @(posedge sclk);
            got[i] = sdat_out;
            win_ok = win_ok & sdat_oe;
        end
        @(posedge sclk);
        win_ok = win_ok & !sdat_oe;
        check({req, " R5 oe window"}, {7'd0, win_ok}, 8'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(posedge sclk);
        check("R1 oe in reset", {7'd0, sdat_oe}, 8'd0);
        check("R1 out in reset", {7'd0, sdat_out}, 8'd0);
        rst = 1'b0;

        // R1: registers read as zero after reset
        rd(5'd0, "R1", got);  check("R1 reg0 zero", got, 8'h00);
        rd(5'd31, "R1", got); check("R1 reg31 zero", got, 8'h00);

        // R3, R8: table of writes then reads
        for (int v = 0; v < NVEC; v++) wr(VEC[v][12:8], VEC[v][7:0], 1'b0);
        for (int v = 0; v < NVEC; v++) begin
            rd(VEC[v][12:8], "R4", got);
            check("R3 R4 R8 table readback", got, VEC[v][7:0]);
        end
        rd(5'd7, "R8", got); check("R8 untouched neighbour", got, 8'h00);

        // R2: idle zeros ignored before a frame
        repeat (9) send_bit(1'b0);
        check("R2 no drive when idle", {7'd0, sdat_oe}, 8'd0);
        rd(5'd31, "R2", got); check("R2 read after idle", got, 8'h3C);

        // R7: 1 on the gap edge is ignored
        wr(5'd9, 8'hC3, 1'b1);
        rd(5'd9, "R7", got); check("R7 gap one ignored", got, 8'hC3);
        rd(5'd0, "R7", got); check("R7 later frame aligned", got, 8'hA5);

        // R6: invalid operation codes abandon the frame
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 14; i++) begin
            send_bit(1'b0);
            check("R6 no drive after op 01", {7'd0, sdat_oe}, 8'd0);
        end
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0);
        rd(5'd5, "R6", got); check("R6 reg unchanged after op 11", got, 8'hFF);

        // R1: reset clears written registers
        @(posedge sclk);
        rst = 1'b1;
        repeat (2) @(posedge sclk);
        rst = 1'b0;
        rd(5'd5, "R1", got); check("R1 cleared by reset", got, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule